// File: doc/BRIEF.md
# Deterministic Quantum Store Buffer

This block is a private store buffer for one thread of a deterministic multicore. During the parallel phase of a quantum round, every store the thread issues is held here and nothing reaches shared memory. When the global commit point comes, a sequencer outside the block raises `cmt_go` for each thread in ascending thread ID order. The next thread's go is taken from the previous thread's `cmt_done`. The buffer then writes its entries to a simple memory write port, one per cycle. Publication order therefore depends only on thread ID and allocation order, never on timing.

A store to an address already in the buffer merges into that entry byte by byte, so one commit writes each address once. Loads from the owning thread look up the buffer. Bytes the thread has buffered are forwarded. All other bytes come from the memory read data that the caller presents. For a context switch, the buffer is streamed out (save) and later streamed back (restore). A store to a new address when the buffer is full is dropped and raises a trap, so that software can commit early. Atomic operations never pass through this block.

Top module: `quantum_store_buf`

## Requirements
- R1: After reset the buffer is empty, and `mem_wr_en`, `sv_valid`, `cmt_done`, `sv_done`, `trap_full`, `buf_full` and `ld_hit` are all 0. Outside a commit, `mem_wr_en` stays 0 whatever stores arrive.
- R2: A store whose address matches a buffered entry updates that entry in place. Bytes whose `st_be` bit is 1 take the new data. The entry's byte-enable becomes the OR of old and new. No new entry is allocated. Byte b of the data is bits 8b+7..8b and is governed by `st_be[b]`.
- R3: When `ld_addr` matches a buffered entry, `ld_hit` is 1 in the same cycle. `ld_data` takes each byte from the entry where that entry's byte-enable bit is 1, and from `mem_rd_data` otherwise.
- R4: When `ld_addr` matches no buffered entry, `ld_hit` is 0 and `ld_data` equals `mem_rd_data`.
- R5: When `cmt_go` is sampled high with a non-empty buffer, the write port runs from the next cycle. `mem_wr_en` is 1 for exactly one cycle per entry, in allocation order, carrying that entry's address, merged data and byte-enable on `ob_addr`/`ob_data`/`ob_be`. `cmt_done` is high for one cycle, in the cycle after the last write, and the buffer is empty from then on.
- R6: When `cmt_go` is sampled high with an empty buffer, nothing is written and `cmt_done` pulses in the next cycle.
- R7: `buf_full` is 1 exactly while 16 entries are held. A store to a new address while the buffer is full is dropped, and `trap_full` pulses in the next cycle. A store that hits an entry while the buffer is full still merges, with no trap. A restore beat while the buffer is full is dropped.
- R8: When `sv_req` is sampled high with a non-empty buffer, the valid entries stream out from the next cycle, one per cycle in allocation order, on `sv_valid` with `ob_*`. `sv_done` pulses in the cycle after the last beat and the buffer is then empty. With an empty buffer, `sv_done` pulses in the next cycle.
- R9: Each `rs_valid` beat appends its address, data and byte-enable as a new valid entry after those already held. Restoring a saved stream and then committing writes the same entries in the same order.
- R10: While a commit or save stream is running, `st_valid` and `rs_valid` are ignored. When `cmt_go` and `sv_req` are high in the same cycle, the commit is taken. In an idle cycle with both `rs_valid` and `st_valid`, the restore beat is taken and the store is dropped.
- R11: A store accepted in the same cycle that `cmt_go` is sampled belongs to that commit and is written with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte-enable |
| ld_addr | input | 32 | Load lookup address |
| mem_rd_data | input | 32 | Data read from memory for the same load |
| ld_hit | output | 1 | Load matches a buffered entry |
| ld_data | output | 32 | Forwarded load data |
| cmt_go | input | 1 | This thread's turn to commit |
| cmt_done | output | 1 | Commit finished (one-cycle pulse) |
| mem_wr_en | output | 1 | Memory write strobe during commit |
| sv_req | input | 1 | Start a save stream |
| sv_valid | output | 1 | Save stream beat valid |
| sv_done | output | 1 | Save finished (one-cycle pulse) |
| ob_addr | output | 32 | Outgoing entry address (commit or save) |
| ob_data | output | 32 | Outgoing entry data |
| ob_be | output | 4 | Outgoing entry byte-enable |
| rs_valid | input | 1 | Restore beat |
| rs_addr | input | 32 | Restore address |
| rs_data | input | 32 | Restore data |
| rs_be | input | 4 | Restore byte-enable |
| buf_full | output | 1 | All entries in use |
| trap_full | output | 1 | Store dropped for lack of space (one-cycle pulse) |

## Verification
The hardest state to reach from the ports is a full buffer under pressure. In that state a new-address store must trap while a store to a held address must still merge, and a restore beat must vanish. The stimulus first fills all sixteen slots with distinct addresses. It then presents a new address, a held address and a restore beat on consecutive cycles before committing, so that the drain shows exactly which entries survived. Arrival of a store on the exact `cmt_go` cycle, and of stores and restore beats in the middle of a drain, is forced by driving those inputs in the same task cycle. A cycle-accurate queue model compares every output on every clock.

// File: rtl/qsb_pkg.sv
package qsb_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DRAIN = 2'd1,
    SQ_SAVE  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/qsb_cam.sv
module qsb_cam #(
  parameter  int DEPTH = 16,
  parameter  int AW    = 32,
  parameter  int DW    = 32,
  parameter  int NQ    = 2,
  localparam int BW    = DW / 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic [CW-1:0]          fill,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [BW-1:0]          wr_be,
  input  logic [NQ-1:0][AW-1:0]  q_addr,
  output logic [NQ-1:0]          q_hit,
  output logic [NQ-1:0][IW-1:0]  q_idx,
  output logic [NQ-1:0][DW-1:0]  q_data,
  output logic [NQ-1:0][BW-1:0]  q_be,
  input  logic [IW-1:0]          rd_idx,
  output logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_data,
  output logic [BW-1:0]          rd_be
);
  logic [AW-1:0] addr_m [DEPTH];
  logic [DW-1:0] data_m [DEPTH];
  logic [BW-1:0] be_m   [DEPTH];

  // payload storage needs no reset: validity comes from fill
  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_m[wr_idx] <= wr_addr;
      data_m[wr_idx] <= wr_data;
      be_m[wr_idx]   <= wr_be;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_query
    logic [DEPTH-1:0] hv;
    logic [IW-1:0]    ix;
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign hv[i] = (CW'(i) < fill) && (addr_m[i] == q_addr[q]);
    end
    // addresses are unique among valid entries, so any encoder works
    always_comb begin
      ix = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (hv[i]) ix = IW'(i);
      end
    end
    assign q_hit[q]  = |hv;
    assign q_idx[q]  = ix;
    assign q_data[q] = data_m[ix];
    assign q_be[q]   = be_m[ix];
  end

  assign rd_addr = addr_m[rd_idx];
  assign rd_data = data_m[rd_idx];
  assign rd_be   = be_m[rd_idx];
endmodule

// File: rtl/qsb_seq.sv
module qsb_seq
  import qsb_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmt_go,
  input  logic          sv_req,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] fill_next,
  output logic          idle,
  output logic          drain_en,
  output logic          save_en,
  output logic [IW-1:0] rd_idx,
  output logic          clr,
  output logic          cmt_done,
  output logic          sv_done
);
  sq_state_e     st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          cd_q, cd_d, sd_q, sd_d;
  logic          last;

  assign last = (CW'(idx_q) + CW'(1)) == fill;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    cd_d  = 1'b0;
    sd_d  = 1'b0;
    clr   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (cmt_go) begin
          if (fill_next == '0) cd_d = 1'b1;
          else begin
            st_d  = SQ_DRAIN;
            idx_d = '0;
          end
        end else if (sv_req) begin
          if (fill_next == '0) sd_d = 1'b1;
          else begin
            st_d  = SQ_SAVE;
            idx_d = '0;
          end
        end
      end
      SQ_DRAIN, SQ_SAVE: begin
        if (last) begin
          st_d = SQ_IDLE;
          clr  = 1'b1;
          if (st_q == SQ_DRAIN) cd_d = 1'b1;
          else                  sd_d = 1'b1;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
      cd_q  <= 1'b0;
      sd_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      cd_q  <= cd_d;
      sd_q  <= sd_d;
    end
  end

  assign idle     = (st_q == SQ_IDLE);
  assign drain_en = (st_q == SQ_DRAIN);
  assign save_en  = (st_q == SQ_SAVE);
  assign rd_idx   = idx_q;
  assign cmt_done = cd_q;
  assign sv_done  = sd_q;
endmodule

// File: rtl/quantum_store_buf.sv
module quantum_store_buf #(
  parameter  int DEPTH = 16,
  parameter  int AW    = 32,
  parameter  int DW    = 32,
  localparam int BW    = DW / 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  input  logic          cmt_go,
  output logic          cmt_done,
  output logic          mem_wr_en,
  input  logic          sv_req,
  output logic          sv_valid,
  output logic          sv_done,
  output logic [AW-1:0] ob_addr,
  output logic [DW-1:0] ob_data,
  output logic [BW-1:0] ob_be,
  input  logic          rs_valid,
  input  logic [AW-1:0] rs_addr,
  input  logic [DW-1:0] rs_data,
  input  logic [BW-1:0] rs_be,
  output logic          buf_full,
  output logic          trap_full
);
  localparam int QST = 0;  // query port used by stores
  localparam int QLD = 1;  // query port used by loads

  logic [1:0]   rsy_q;
  logic         rst_ni;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          trap_q;
  logic          idle, seq_clr;
  logic          full, rs_take, st_take, st_new, st_merge, trap_d;

  logic [1:0]          q_hit;
  logic [1:0][IW-1:0]  q_idx;
  logic [1:0][DW-1:0]  q_data;
  logic [1:0][BW-1:0]  q_be;
  logic [1:0][AW-1:0]  q_addr;
  logic [IW-1:0]       rd_idx;

  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, mrg_data;
  logic [BW-1:0] wr_be;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsy_q <= 2'b00;
    else        rsy_q <= {rsy_q[0], 1'b1};
  end
  assign rst_ni = rsy_q[1];

  assign full     = (cnt_q == CW'(DEPTH));
  assign rs_take  = idle & rs_valid & ~full;
  assign st_take  = idle & st_valid & ~rs_valid;
  assign st_merge = st_take & q_hit[QST];
  assign st_new   = st_take & ~q_hit[QST] & ~full;
  assign trap_d   = st_take & ~q_hit[QST] & full;

  assign q_addr[QST] = st_addr;
  assign q_addr[QLD] = ld_addr;

  for (genvar b = 0; b < BW; b++) begin : g_byte
    assign mrg_data[8*b +: 8] = st_be[b] ? st_data[8*b +: 8] : q_data[QST][8*b +: 8];
    assign ld_data[8*b +: 8]  = (q_hit[QLD] & q_be[QLD][b]) ? q_data[QLD][8*b +: 8]
                                                            : mem_rd_data[8*b +: 8];
  end
  assign ld_hit = q_hit[QLD];

  always_comb begin
    wr_en   = rs_take | st_new | st_merge;
    wr_idx  = cnt_q[IW-1:0];
    wr_addr = st_addr;
    wr_data = st_data;
    wr_be   = st_be;
    if (rs_take) begin
      wr_addr = rs_addr;
      wr_data = rs_data;
      wr_be   = rs_be;
    end else if (st_merge) begin
      wr_idx  = q_idx[QST];
      wr_data = mrg_data;
      wr_be   = q_be[QST] | st_be;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (seq_clr)                cnt_d = '0;
    else if (rs_take | st_new)  cnt_d = cnt_q + CW'(1);
  end
  assign cnt_en = seq_clr | rs_take | st_new;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      trap_q <= trap_d;
    end
  end

  qsb_cam #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .NQ(2)) u_cam (
    .clk     (clk),
    .fill    (cnt_q),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .q_addr  (q_addr),
    .q_hit   (q_hit),
    .q_idx   (q_idx),
    .q_data  (q_data),
    .q_be    (q_be),
    .rd_idx  (rd_idx),
    .rd_addr (ob_addr),
    .rd_data (ob_data),
    .rd_be   (ob_be)
  );

  qsb_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .cmt_go    (cmt_go),
    .sv_req    (sv_req),
    .fill      (cnt_q),
    .fill_next (cnt_d),
    .idle      (idle),
    .drain_en  (mem_wr_en),
    .save_en   (sv_valid),
    .rd_idx    (rd_idx),
    .clr       (seq_clr),
    .cmt_done  (cmt_done),
    .sv_done   (sv_done)
  );

  assign buf_full  = full;
  assign trap_full = trap_q;
endmodule

// File: rtl/qsb_chk.sv
module qsb_chk (
  input logic clk,
  input logic rst_n,
  input logic cmt_go,
  input logic cmt_done,
  input logic mem_wr_en,
  input logic sv_req,
  input logic sv_valid,
  input logic sv_done,
  input logic buf_full,
  input logic trap_full
);
  p_drain_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_en) |-> $past(cmt_go));
  p_cdone_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_done |-> ($past(mem_wr_en) || $past(cmt_go)));
  p_empty_after_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_done |-> !buf_full);
  p_save_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sv_valid) |-> $past(sv_req));
  p_sdone_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sv_done |-> ($past(sv_valid) || $past(sv_req)));
  p_trap_needs_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_full |-> $past(buf_full));
  p_one_stream_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && sv_valid));
  p_one_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmt_done, sv_done}));
endmodule

bind quantum_store_buf qsb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmt_go    (cmt_go),
  .cmt_done  (cmt_done),
  .mem_wr_en (mem_wr_en),
  .sv_req    (sv_req),
  .sv_valid  (sv_valid),
  .sv_done   (sv_done),
  .buf_full  (buf_full),
  .trap_full (trap_full)
);

// File: tb/sim_quantum_store_buf.sv
module sim_quantum_store_buf;
  localparam int PER = 10;
  localparam int NENT = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic st_valid, cmt_go, sv_req, rs_valid;
  logic [31:0] st_addr, st_data, ld_addr, mem_rd_data, rs_addr, rs_data;
  logic [3:0]  st_be, rs_be;
  logic ld_hit, cmt_done, mem_wr_en, sv_valid, sv_done, buf_full, trap_full;
  logic [31:0] ld_data, ob_addr, ob_data;
  logic [3:0]  ob_be;

  always #(PER/2) clk = ~clk;

  quantum_store_buf u0 (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .ld_addr(ld_addr), .mem_rd_data(mem_rd_data), .ld_hit(ld_hit), .ld_data(ld_data),
    .cmt_go(cmt_go), .cmt_done(cmt_done), .mem_wr_en(mem_wr_en),
    .sv_req(sv_req), .sv_valid(sv_valid), .sv_done(sv_done),
    .ob_addr(ob_addr), .ob_data(ob_data), .ob_be(ob_be),
    .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_data(rs_data), .rs_be(rs_be),
    .buf_full(buf_full), .trap_full(trap_full)
  );

  int n_run = 0;
  int n_fail = 0;
  int ncyc = 0;
  string scen = "reset";

  // reference model: queues in allocation order
  bit [31:0] m_addr[$];
  bit [31:0] m_data[$];
  bit [3:0]  m_be[$];
  int  mode = 0;   // 0 idle, 1 committing, 2 saving
  int  pos = 0;
  bit  e_cd = 0, e_sd = 0, e_trap = 0;
  bit [31:0] pick_addr = 32'h0;
  bit [31:0] s_addr[$];
  bit [31:0] s_data[$];
  bit [3:0]  s_be[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) actual=%0h expected=%0h", req, scen, act, exp);
    end
  endtask

  task automatic compare();
    int hi;
    bit [31:0] eld;
    hi = -1;
    foreach (m_addr[i]) if (m_addr[i] == ld_addr) hi = i;
    eld = mem_rd_data;
    if (hi >= 0)
      for (int b = 0; b < 4; b++)
        if (m_be[hi][b]) eld[8*b +: 8] = m_data[hi][8*b +: 8];
    chk(ld_hit === (hi >= 0), (hi >= 0) ? "R3" : "R4", 64'(ld_hit), 64'(hi >= 0));
    chk(ld_data === eld, (hi >= 0) ? "R3" : "R4", 64'(ld_data), 64'(eld));
    chk(buf_full === (m_addr.size() == NENT), "R7", 64'(buf_full), 64'(m_addr.size() == NENT));
    chk(trap_full === e_trap, "R7", 64'(trap_full), 64'(e_trap));
    chk(cmt_done === e_cd, "R5", 64'(cmt_done), 64'(e_cd));
    chk(sv_done === e_sd, "R8", 64'(sv_done), 64'(e_sd));
    chk(mem_wr_en === (mode == 1), (mode == 1) ? "R5" : "R1", 64'(mem_wr_en), 64'(mode == 1));
    chk(sv_valid === (mode == 2), "R8", 64'(sv_valid), 64'(mode == 2));
    if (mode != 0) begin
      chk({ob_addr, ob_data} === {m_addr[pos], m_data[pos]}, (mode == 1) ? "R5" : "R8",
          {ob_addr, ob_data}, {m_addr[pos], m_data[pos]});
      chk(ob_be === m_be[pos], (mode == 1) ? "R5" : "R8", 64'(ob_be), 64'(m_be[pos]));
    end
  endtask

  task automatic model_step();
    bit ncd, nsd, ntr;
    int hi;
    ncd = 0; nsd = 0; ntr = 0;
    if (!rst_n) begin
      m_addr.delete(); m_data.delete(); m_be.delete(); mode = 0;
    end else if (mode == 0) begin
      if (rs_valid) begin
        if (m_addr.size() < NENT) begin
          m_addr.push_back(rs_addr); m_data.push_back(rs_data); m_be.push_back(rs_be);
        end
      end else if (st_valid) begin
        hi = -1;
        foreach (m_addr[i]) if (m_addr[i] == st_addr) hi = i;
        if (hi >= 0) begin
          for (int b = 0; b < 4; b++)
            if (st_be[b]) m_data[hi][8*b +: 8] = st_data[8*b +: 8];
          m_be[hi] = m_be[hi] | st_be;
        end else if (m_addr.size() < NENT) begin
          m_addr.push_back(st_addr); m_data.push_back(st_data); m_be.push_back(st_be);
        end else ntr = 1;
      end
      if (cmt_go) begin
        if (m_addr.size() == 0) ncd = 1;
        else begin mode = 1; pos = 0; end
      end else if (sv_req) begin
        if (m_addr.size() == 0) nsd = 1;
        else begin mode = 2; pos = 0; end
      end
    end else begin
      if (pos == m_addr.size() - 1) begin
        if (mode == 1) ncd = 1; else nsd = 1;
        m_addr.delete(); m_data.delete(); m_be.delete();
        mode = 0;
      end else pos++;
    end
    e_cd = ncd; e_sd = nsd; e_trap = ntr;
  endtask

  // one clock: inputs already set at the negative edge
  task automatic cyc();
    ncyc++;
    ld_addr = (ncyc % 3 == 0) ? (32'hF000_0000 | 32'(ncyc)) : pick_addr;
    mem_rd_data = {16'(ncyc * 37), 16'hA5C3};
    #(PER/4);
    compare();
    if (sv_valid) begin
      s_addr.push_back(ob_addr); s_data.push_back(ob_data); s_be.push_back(ob_be);
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    st_valid = 0; cmt_go = 0; sv_req = 0; rs_valid = 0;
  endtask

  task automatic store(input bit [31:0] a, input bit [31:0] d, input bit [3:0] be);
    st_valid = 1; st_addr = a; st_data = d; st_be = be; pick_addr = a;
    cyc();
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic run_out();
    for (int i = 0; i < 40 && (mode != 0 || e_cd || e_sd); i++) cyc();
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired (%s) actual=%0d expected=0", scen, ncyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; st_valid = 0; cmt_go = 0; sv_req = 0; rs_valid = 0;
    st_addr = 0; st_data = 0; st_be = 0; rs_addr = 0; rs_data = 0; rs_be = 0;
    ld_addr = 0; mem_rd_data = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk({mem_wr_en, sv_valid, cmt_done, sv_done, trap_full, buf_full, ld_hit} === 7'b0,
        "R1", 64'({mem_wr_en, sv_valid, cmt_done, sv_done, trap_full, buf_full, ld_hit}), 64'(0));
    rst_n = 1;
    idle_n(3);

    scen = "R1 buffered stores stay private";
    for (int i = 0; i < 5; i++) store(32'h40 + 32'(i*4), 32'h1111_0000 + 32'(i), 4'hF);
    idle_n(3);

    scen = "R2 merge in place";
    store(32'h80, 32'hAABB_CCDD, 4'b0011);
    store(32'h80, 32'h1122_3344, 4'b1100);
    idle_n(2);
    chk(ld_hit === 1'b1 || ld_addr != 32'h80, "R2", 64'(ld_hit), 64'(1));
    store(32'h80, 32'h5566_7788, 4'b0100);
    idle_n(2);

    scen = "R3 partial bytes forward, R4 miss passes through";
    store(32'hC0, 32'hDEAD_BEEF, 4'b1001);
    pick_addr = 32'hC0; idle_n(3);
    pick_addr = 32'h7777_0000; idle_n(3);

    scen = "R11 store on go cycle, R5 commit order";
    st_valid = 1; st_addr = 32'hE0; st_data = 32'hCAFE_F00D; st_be = 4'hF; cmt_go = 1;
    cyc();
    run_out();
    idle_n(2);

    scen = "R6 commit of empty buffer";
    cmt_go = 1; cyc();
    run_out();

    scen = "R7 full buffer trap and merge";
    for (int i = 0; i < NENT; i++) store(32'h100 + 32'(i*4), 32'h2000_0000 + 32'(i), 4'hF);
    idle_n(1);
    store(32'h500, 32'h0BAD_0BAD, 4'hF);
    store(32'h108, 32'h0000_00EE, 4'b0001);
    rs_valid = 1; rs_addr = 32'h600; rs_data = 32'h1; rs_be = 4'h1; cyc();
    idle_n(2);
    scen = "R10 inputs ignored while draining";
    cmt_go = 1; sv_req = 1; cyc();
    store(32'h700, 32'h3, 4'hF);
    rs_valid = 1; rs_addr = 32'h704; rs_data = 32'h4; rs_be = 4'h3; cyc();
    run_out();
    idle_n(2);

    scen = "R8 save stream";
    for (int i = 0; i < 4; i++) store(32'h200 + 32'(i*8), 32'h3300_0000 + 32'(i*5), 4'(i + 3));
    s_addr.delete(); s_data.delete(); s_be.delete();
    sv_req = 1; cyc();
    run_out();
    sv_req = 1; cyc();
    run_out();

    scen = "R9 restore then commit";
    foreach (s_addr[i]) begin
      rs_valid = 1; rs_addr = s_addr[i]; rs_data = s_data[i]; rs_be = s_be[i];
      pick_addr = s_addr[i];
      cyc();
    end
    chk(buf_full === 1'b0 && s_addr.size() == 4, "R9", 64'(s_addr.size()), 64'(4));
    scen = "R10 restore beats over a store";
    rs_valid = 1; rs_addr = 32'h300; rs_data = 32'h9; rs_be = 4'hF;
    st_valid = 1; st_addr = 32'h304; st_data = 32'h8; st_be = 4'hF;
    cyc();
    pick_addr = 32'h304; idle_n(2);
    scen = "R9 restored entries commit in order";
    cmt_go = 1; cyc();
    run_out();
    idle_n(3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule